// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This unit owns the 32-bit program counter of a small load/store processor and works out the address of the next instruction on every clock. Each cycle it looks at the instruction word currently being executed together with two operand values supplied by the register file. From these it decides whether the program falls through to the next word, jumps to an absolute address, or takes a PC-relative branch-if-equal.

The decision is named as one of four flow kinds. FLOW_SEQ covers every opcode other than jump and branch-if-equal, including the no-op, and moves to PC+4. FLOW_JUMP (opcode 2) moves to an absolute word address inside the current 256 MiB region. FLOW_BR_TAKEN (opcode 31 with equal operands) moves by a signed word offset measured from PC+4. FLOW_BR_FALL (opcode 31 with unequal operands) moves to PC+4. The kind is chosen fresh from the inputs in every cycle. The only stored state is the PC register, which changes at a clock edge only when the advance enable is high. A synchronous reset returns it to address zero. The selection of the operand registers from instruction bits 25:21 and 20:16 is done outside this unit, and the register file supplies their contents on the two compare inputs. A combinational redirect flag tells the fetch logic that the coming edge leaves the sequential path.

Top module: `pcseq_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0 after that edge, whatever `adv_en` and the other inputs are.
- R2: While `adv_en` is low (and `rst` low), `pc` keeps its value across the edge and `redirect` is low, whatever the instruction and operands are.
- R3: With `adv_en` high, any opcode (instruction bits 31:26) other than 2 and 31, including the all-zero no-op, gives next `pc` = `pc` + 4 modulo 2^32.
- R4: Opcode 2 (jump) gives next `pc` = {(`pc`+4)[31:28], `instr`[25:0], 2'b00}, so the upper four bits come from the incremented PC.
- R5: Opcode 31 with `cmp_a` == `cmp_b` gives next `pc` = `pc` + 4 + (sign-extended `instr`[15:0] shifted left by 2), modulo 2^32.
- R6: Opcode 31 with `cmp_a` != `cmp_b` gives next `pc` = `pc` + 4.
- R7: `redirect` is high in exactly those cycles where `adv_en` is high, `rst` is low, and the instruction is a jump or a branch-if-equal with equal operands.
- R8: Starting from reset, `pc` bits 1:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; low stalls the PC |
| instr | input | 32 | Instruction word executing this cycle |
| cmp_a | input | 32 | First operand for the equality test |
| cmp_b | input | 32 | Second operand for the equality test |
| pc | output | 32 | Current program counter, fetch address |
| redirect | output | 1 | High when the coming edge takes a jump or taken branch |

## Verification
The hardest cases to reach are those at the top of the address space. A jump must keep bits 31:28 from PC+4, and sequential flow must wrap from 0xFFFFFFFC to 0. Jumps alone can never set the upper bits. So the bench first takes a branch with a small negative offset from address 0, which lands the PC at 0xFFFFFFF8. From there it checks a jump that must keep the upper nibble at 0xF, then returns there and checks the sequential wrap through zero. Every one of the 64 opcodes is swept with both equal and unequal operands and with the enable toggled. The expected PC and redirect values are computed arithmetically in the bench.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int unsigned OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd31;

    typedef enum logic [1:0] {
        FLOW_SEQ      = 2'd0,
        FLOW_JUMP     = 2'd1,
        FLOW_BR_TAKEN = 2'd2,
        FLOW_BR_FALL  = 2'd3
    } flow_kind_t;

endpackage

// File: rtl/pcseq_compare.sv
module pcseq_compare #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              same
);
    logic [DATA_W-1:0] diff;

    always_comb begin
        diff = lhs ^ rhs;
        same = ~|diff;
    end
endmodule

// File: rtl/pcseq_decode.sv
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             operands_equal,
    output flow_kind_t       kind
);
    always_comb begin
        if (opcode == OPC_JUMP) begin
            kind = FLOW_JUMP;
        end else if (opcode == OPC_BEQ) begin
            kind = operands_equal ? FLOW_BR_TAKEN : FLOW_BR_FALL;
        end else begin
            kind = FLOW_SEQ;
        end
    end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned JADR_W = 26,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned STEP   = 4
) (
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [JADR_W-1:0] field,
    input  flow_kind_t        kind,
    output logic [ADDR_W-1:0] pc_next
);
    localparam int unsigned ALIGN_W = $clog2(STEP);
    localparam int unsigned HI_W    = ADDR_W - JADR_W - ALIGN_W;
    localparam int unsigned SEXT_W  = ADDR_W - OFF_W - ALIGN_W;

    logic [ADDR_W-1:0] incr;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] jump_dst;
    logic [ADDR_W-1:0] branch_dst;

    always_comb begin
        incr       = pc_now + ADDR_W'(STEP);
        offset     = {{SEXT_W{field[OFF_W-1]}}, field[OFF_W-1:0], {ALIGN_W{1'b0}}};
        jump_dst   = {incr[ADDR_W-1 -: HI_W], field, {ALIGN_W{1'b0}}};
        branch_dst = incr + offset;

        unique case (kind)
            FLOW_SEQ:      pc_next = incr;
            FLOW_JUMP:     pc_next = jump_dst;
            FLOW_BR_TAKEN: pc_next = branch_dst;
            FLOW_BR_FALL:  pc_next = incr;
            default:       pc_next = incr;
        endcase
    end
endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
    import pcseq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned JADR_W  = 26,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned STEP    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv_en,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  cmp_a,
    input  logic [ADDR_W-1:0]  cmp_b,
    output logic [ADDR_W-1:0]  pc,
    output logic               redirect
);
    localparam int unsigned ALIGN_W = $clog2(STEP);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic              ops_same;
    flow_kind_t        kind;

    pcseq_compare #(.DATA_W(ADDR_W)) u_cmp (
        .lhs  (cmp_a),
        .rhs  (cmp_b),
        .same (ops_same)
    );

    pcseq_decode u_dec (
        .opcode         (instr[INSTR_W-1 -: OPC_W]),
        .operands_equal (ops_same),
        .kind           (kind)
    );

    pcseq_target #(
        .ADDR_W (ADDR_W),
        .JADR_W (JADR_W),
        .OFF_W  (OFF_W),
        .STEP   (STEP)
    ) u_tgt (
        .pc_now  (pc_q),
        .field   (instr[JADR_W-1:0]),
        .kind    (kind),
        .pc_next (pc_d)
    );

    // State register: the program counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (adv_en) begin
            pc_q <= pc_d;
        end
    end

    // Outputs.
    always_comb begin
        pc = pc_q;
        unique case (kind)
            FLOW_JUMP, FLOW_BR_TAKEN: redirect = adv_en & ~rst;
            FLOW_SEQ, FLOW_BR_FALL:   redirect = 1'b0;
            default:                  redirect = 1'b0;
        endcase
    end

    // R1: first cycle after reset shows address zero.
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0));

    // R2: stall holds the PC and never redirects.
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> (pc == $past(pc)));

    assert_stall_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !adv_en |-> !redirect);

    // R3: advancing without redirect steps by one word.
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !redirect) |=> (pc == $past(pc) + ADDR_W'(STEP)));

    // R4: jump places the target field into the word-address bits.
    assert_jump_field_R4: assert property (@(posedge clk) disable iff (rst)
        (adv_en && instr[INSTR_W-1 -: OPC_W] == OPC_JUMP)
        |=> (pc[JADR_W+ALIGN_W-1:0] == {$past(instr[JADR_W-1:0]), {ALIGN_W{1'b0}}}));

    // R7: a branch-if-equal with unequal operands never redirects.
    assert_fall_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (instr[INSTR_W-1 -: OPC_W] == OPC_BEQ && cmp_a != cmp_b) |-> !redirect);

    // R8: the PC stays word aligned.
    assert_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        pc[ALIGN_W-1:0] == '0);

endmodule

// File: tb/pcseq_unit_test.sv
`timescale 1ns/1ps
module pcseq_unit_test;

    logic        clk;
    logic        rst;
    logic        adv_en;
    logic [31:0] instr;
    logic [31:0] cmp_a;
    logic [31:0] cmp_b;
    logic [31:0] pc;
    logic        redirect;

    int checks;
    int errors;
    logic [31:0] model_pc;
    bit done;

    pcseq_unit uut (
        .clk      (clk),
        .rst      (rst),
        .adv_en   (adv_en),
        .instr    (instr),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .pc       (pc),
        .redirect (redirect)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    // Drive one cycle, check redirect before the edge and pc after it.
    task automatic step(input logic r, input logic en, input logic [31:0] iw,
                        input logic [31:0] a, input logic [31:0] b);
        logic [5:0]  op;
        logic [31:0] p4;
        logic [31:0] nxt;
        logic        redir_exp;
        string       tag;
        @(negedge clk);
        rst = r; adv_en = en; instr = iw; cmp_a = a; cmp_b = b;
        op = iw[31:26];
        p4 = model_pc + 32'd4;
        redir_exp = 1'b0;
        if (op == 6'd2) begin
            nxt = {p4[31:28], iw[25:0], 2'b00}; tag = "R4"; redir_exp = 1'b1;
        end else if (op == 6'd31 && a == b) begin
            nxt = p4 + {{14{iw[15]}}, iw[15:0], 2'b00}; tag = "R5"; redir_exp = 1'b1;
        end else if (op == 6'd31) begin
            nxt = p4; tag = "R6";
        end else begin
            nxt = p4; tag = "R3";
        end
        if (r) begin
            nxt = 32'd0; tag = "R1"; redir_exp = 1'b0;
        end else if (!en) begin
            nxt = model_pc; tag = "R2"; redir_exp = 1'b0;
        end
        #1;
        check("R7", {31'd0, redirect}, {31'd0, redir_exp});
        @(posedge clk);
        #1;
        model_pc = nxt;
        check(tag, pc, model_pc);
        check("R8", {30'd0, pc[1:0]}, 32'd0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; done = 0; model_pc = 32'd0;
        rst = 1'b1; adv_en = 1'b0; instr = '0; cmp_a = '0; cmp_b = '0;
        // R1: reset state
        step(1'b1, 1'b1, 32'h0800_1234, 32'd0, 32'd0);
        step(1'b0, 1'b1, 32'h0000_0000, 32'd1, 32'd2); // no-op, R3

        // Sweep every opcode with varied fields, operands and enable.
        for (int op = 0; op < 64; op++) begin
            for (int k = 0; k < 4; k++) begin
                logic [25:0] fld;
                logic [31:0] a;
                fld = 26'h155_5A5A ^ 26'(op * 26'h0B_3F11) ^ 26'(k * 26'h1C_8003);
                a = 32'hDEAD_0000 + 32'(op);
                step(1'b0, (k != 2), {6'(op), fld}, a, (k[0] ? a : ~a));
            end
        end

        // Stall with a jump presented: R2
        step(1'b0, 1'b0, {6'd2, 26'h3FF_FFFF}, 32'd0, 32'd0);

        // Reset mid-run, adv_en low: R1
        step(1'b1, 1'b0, {6'd2, 26'h000_0100}, 32'd0, 32'd0);
        // Branch back by 3 words from 0: 4 - 12 = FFFFFFF8 (R5 wrap)
        step(1'b0, 1'b1, {6'd31, 5'd1, 5'd2, 16'hFFFD}, 32'd7, 32'd7);
        check("R5", pc, 32'hFFFF_FFF8);
        // Jump keeps upper nibble F from incremented PC: R4
        step(1'b0, 1'b1, {6'd2, 26'h000_0040}, 32'd0, 32'd1);
        check("R4", pc, 32'hF000_0100);
        // Back to high end and wrap sequentially: R3
        step(1'b1, 1'b1, 32'd0, 32'd0, 32'd0);
        step(1'b0, 1'b1, {6'd31, 10'd0, 16'hFFFE}, 32'd3, 32'd3);
        check("R5", pc, 32'hFFFF_FFFC);
        step(1'b0, 1'b1, 32'h0000_0000, 32'd0, 32'd0);
        check("R3", pc, 32'h0000_0000);
        // Largest forward branch, then unequal branch: R5, R6
        step(1'b0, 1'b1, {6'd31, 10'd0, 16'h7FFF}, 32'd9, 32'd9);
        check("R5", pc, 32'h0002_0000);
        step(1'b0, 1'b1, {6'd31, 10'd0, 16'h7FFF}, 32'd9, 32'd8);
        check("R6", pc, 32'h0002_0004);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule